// File: doc/BRIEF.md
# Register-Fed Integer ALU with Post-Shift Stage

This block is an integer datapath of parameterised width. Two operand registers, X and Y, are loaded from the outside. A routing stage chooses which of them, or a constant zero, drives each of the two internal operand buses. A function unit then applies one of eight arithmetic or bitwise operations to the buses. A final stage either passes the result on unchanged, halves it or doubles it, and writes it into a result register Z.

One 7-bit control word and a carry input set up each operation. The control word has three fields: operand routing in the top two bits, the function in the middle three bits and the shift action in the low two bits. The status flags (zero, sign, signed overflow and carry-out) are combinational. They describe the function unit's result before the shift stage, for the values now held in X and Y and for the control word now applied. A sequencer can therefore read the flags of a comparison in the same cycle, without loading Z.

Top module: `mc_shift_alu`

## Requirements
- R1: Operand routing by ctrl[6:5]: 00 gives bus A = X and bus B = Y; 01 gives A = X and B = 0; 10 gives A = Y and B = 0; 11 gives A = Y and B = X.
- R2: Function code ctrl[4:2] = 000 yields A + B + cin. flag_carry is the carry out of the most significant bit.
- R3: Function code 001 yields A − B − (1 − cin), formed as A + ~B + cin. flag_carry is the carry out of that sum, so 1 means no borrow.
- R4: Function code 010 yields B − A − (1 − cin), formed as B + ~A + cin, with its carry out on flag_carry. Route 00 with code 010 and cin = 1 gives Y − X, and flag_sign is then 1 exactly when X > Y for in-range values.
- R5: Function codes 011 OR, 100 AND, 101 (NOT A) AND B, 110 XOR and 111 XNOR operate bitwise. For these codes flag_carry and flag_overflow are 0.
- R6: For codes 000 to 010, flag_overflow is the XOR of the carry into the sign bit and the carry out of it. It is 1 exactly when the two's complement result is wrong.
- R7: flag_zero is 1 when the pre-shift result is all zeros, and flag_sign equals its most significant bit. The shift stage does not alter either flag.
- R8: Shift code ctrl[1:0] writes into Z: 00 the result unchanged; 01 the result shifted right by one with the sign bit copied; 10 the result shifted left by one with a 0 entering the LSB.
- R9: Z changes only on a rising clock edge with z_en = 1 and a shift code other than 11. Shift code 11 and z_en = 0 both leave Z unchanged.
- R10: With rst_n low at a rising edge, X, Y and Z are all cleared to 0. This reset is synchronous and active low.
- R11: X takes x_in at a rising edge only when x_load = 1, and Y takes y_in only when y_load = 1. Each register otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of X, Y and Z |
| x_in | input | W | Data for register X |
| y_in | input | W | Data for register Y |
| x_load | input | 1 | Loads x_in into X at the edge |
| y_load | input | 1 | Loads y_in into Y at the edge |
| ctrl | input | 7 | [6:5] routing, [4:2] function, [1:0] shift |
| cin | input | 1 | Carry input of the arithmetic functions |
| z_en | input | 1 | Write enable of Z |
| z_out | output | W | Result register Z |
| flag_zero | output | 1 | Pre-shift result is zero |
| flag_sign | output | 1 | MSB of pre-shift result |
| flag_overflow | output | 1 | Signed overflow of arithmetic functions |
| flag_carry | output | 1 | Carry out of arithmetic functions |

## Verification
The function unit is exercised with operand pairs that separate its behaviours. A pair of positive values that crosses the signed limit makes carry and overflow differ. A pair of equal operands makes subtraction give zero with no borrow. A negative value divided by two shows whether the sign bit is copied. Operand pairs with distinct bit masks separate each bitwise function from the others. The four routes are each tried with asymmetric X and Y, so a swapped or zeroed bus gives a visibly wrong result. The hold cases (shift code 11, z_en low, a load of only one register) are followed by reads that would expose any change.

// File: rtl/alu_pkg.sv
// Shared control-field encodings for the register-fed ALU.
// Assumes the control word is split 2+3+2 bits, most significant field first.
package alu_pkg;
    typedef enum logic [1:0] {
        SEL_XY = 2'b00,
        SEL_X0 = 2'b01,
        SEL_Y0 = 2'b10,
        SEL_YX = 2'b11
    } opsel_e;

    typedef enum logic [2:0] {
        FN_ADD  = 3'b000,
        FN_SUB  = 3'b001,
        FN_RSUB = 3'b010,
        FN_OR   = 3'b011,
        FN_AND  = 3'b100,
        FN_ANDN = 3'b101,
        FN_XOR  = 3'b110,
        FN_XNOR = 3'b111
    } func_e;

    typedef enum logic [1:0] {
        SH_PASS = 2'b00,
        SH_HALF = 2'b01,
        SH_DBL  = 2'b10,
        SH_HOLD = 2'b11
    } shift_e;
endpackage

// File: rtl/operand_mux.sv
// Routes X, Y or zero onto the two operand buses.
// Assumes the select comes straight from the routing field; purely combinational.
module operand_mux
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  opsel_e         sel,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W-1:0]   bus_a,
    output logic [W-1:0]   bus_b
);
    // Choose the source of each bus
    always_comb begin
        case (sel)
            SEL_XY:  begin bus_a = x; bus_b = y;      end
            SEL_X0:  begin bus_a = x; bus_b = '0;     end
            SEL_Y0:  begin bus_a = y; bus_b = '0;     end
            default: begin bus_a = y; bus_b = x;      end
        endcase
    end
endmodule

// File: rtl/func_unit.sv
// Eight-function arithmetic/logic unit on two W-bit buses.
// Subtractions are done as addition of the inverted operand plus cin.
// Carry and overflow are valid only for the three arithmetic codes, else 0.
// Assumes W >= 2.
module func_unit
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  func_e          fn,
    input  logic [W-1:0]   bus_a,
    input  logic [W-1:0]   bus_b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           ovf
);
    localparam int LOW = W - 1;

    logic [W-1:0] add_p, add_q;
    logic [W-1:0] low_sum;
    logic [1:0]   top_sum;
    logic         c_into_msb;
    logic [W-1:0] sum;
    logic         is_arith;

    // Pick adder operands for add, subtract and reverse subtract
    always_comb begin
        case (fn)
            FN_SUB:  begin add_p = bus_a; add_q = ~bus_b; end
            FN_RSUB: begin add_p = bus_b; add_q = ~bus_a; end
            default: begin add_p = bus_a; add_q = bus_b;  end
        endcase
    end

    // Split adder: low bits, then the sign bit, to expose both carries
    always_comb begin
        low_sum    = {1'b0, add_p[LOW-1:0]} + {1'b0, add_q[LOW-1:0]}
                   + {{(W-1){1'b0}}, cin};
        c_into_msb = low_sum[LOW];
        top_sum    = {1'b0, add_p[W-1]} + {1'b0, add_q[W-1]} + {1'b0, c_into_msb};
        sum        = {top_sum[0], low_sum[LOW-1:0]};
    end

    assign is_arith = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_RSUB);

    // Select the result and qualify the arithmetic flags
    always_comb begin
        case (fn)
            FN_OR:   res = bus_a | bus_b;
            FN_AND:  res = bus_a & bus_b;
            FN_ANDN: res = ~bus_a & bus_b;
            FN_XOR:  res = bus_a ^ bus_b;
            FN_XNOR: res = ~(bus_a ^ bus_b);
            default: res = sum;
        endcase
        cout = is_arith & top_sum[1];
        ovf  = is_arith & (top_sum[1] ^ c_into_msb);
    end
endmodule

// File: rtl/shift_stage.sv
// Post-ALU stage: pass, arithmetic halve or double.
// The hold code is resolved by the Z register's load enable; here it passes.
module shift_stage
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  shift_e         mode,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout
);
    // Apply the requested one-place shift
    always_comb begin
        case (mode)
            SH_HALF: dout = {din[W-1], din[W-1:1]};
            SH_DBL:  dout = {din[W-2:0], 1'b0};
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/mc_shift_alu.sv
// Top: operand registers, routing, function unit, shift stage, Z register.
// Flags are combinational and describe the pre-shift result.
// Synchronous active-low reset clears X, Y and Z.
module mc_shift_alu
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   x_in,
    input  logic [W-1:0]   y_in,
    input  logic           x_load,
    input  logic           y_load,
    input  logic [6:0]     ctrl,
    input  logic           cin,
    input  logic           z_en,
    output logic [W-1:0]   z_out,
    output logic           flag_zero,
    output logic           flag_sign,
    output logic           flag_overflow,
    output logic           flag_carry
);
    logic [W-1:0] x_q, y_q, z_q;
    logic [W-1:0] bus_a, bus_b, alu3, shifted;
    opsel_e       sel;
    func_e        fn;
    shift_e       sh;
    logic         z_load;

    assign sel = opsel_e'(ctrl[6:5]);
    assign fn  = func_e'(ctrl[4:2]);
    assign sh  = shift_e'(ctrl[1:0]);

    operand_mux #(.W(W)) u_mux (
        .sel(sel), .x(x_q), .y(y_q), .bus_a(bus_a), .bus_b(bus_b)
    );

    func_unit #(.W(W)) u_fn (
        .fn(fn), .bus_a(bus_a), .bus_b(bus_b), .cin(cin),
        .res(alu3), .cout(flag_carry), .ovf(flag_overflow)
    );

    shift_stage #(.W(W)) u_sh (
        .mode(sh), .din(alu3), .dout(shifted)
    );

    assign z_load = z_en && (sh != SH_HOLD);

    // Operand registers with independent load enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            if (x_load) x_q <= x_in;
            if (y_load) y_q <= y_in;
        end
    end

    // Result register, written unless disabled or holding
    always_ff @(posedge clk) begin
        if (!rst_n)      z_q <= '0;
        else if (z_load) z_q <= shifted;
    end

    assign z_out     = z_q;
    assign flag_zero = (alu3 == '0);
    assign flag_sign = alu3[W-1];
endmodule

// File: rtl/mc_shift_alu_chk.sv
// Property checker for mc_shift_alu, attached by bind below.
module mc_shift_alu_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [6:0]     ctrl,
    input logic           z_en,
    input logic [W-1:0]   z_out,
    input logic [W-1:0]   alu3,
    input logic           flag_zero,
    input logic           flag_sign,
    input logic           flag_overflow,
    input logic           flag_carry
);
    // R9
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1:0] == 2'b11) |=> (z_out == $past(z_out)));

    // R9
    z_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !z_en |=> (z_out == $past(z_out)));

    // R5
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[4:2] >= 3'b011) |-> (!flag_carry && !flag_overflow));

    // R7
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero |-> !flag_sign);

    // R8
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (z_en && ctrl[1:0] == 2'b00) |=> (z_out == $past(alu3)));

    // R8
    halve_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (z_en && ctrl[1:0] == 2'b01) |=> (z_out[W-1] == z_out[W-2]));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (z_out == '0));
endmodule

bind mc_shift_alu mc_shift_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .z_en(z_en), .z_out(z_out),
    .alu3(alu3), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_overflow(flag_overflow), .flag_carry(flag_carry)
);

// File: tb/tb_mc_shift_alu.sv
`timescale 1ns/1ps
module tb_mc_shift_alu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] x_in = '0, y_in = '0;
    logic         x_load = 1'b0, y_load = 1'b0;
    logic [6:0]   ctrl = '0;
    logic         cin = 1'b0;
    logic         z_en = 1'b0;
    logic [W-1:0] z_out;
    logic         flag_zero, flag_sign, flag_overflow, flag_carry;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [W-1:0] z;
        logic [3:0]   flags;   // {zero, sign, overflow, carry}
        string        tag;
    } exp_t;
    exp_t sb_q[$];

    int xm = 0, ym = 0, zm = 0;

    always #2 clk = ~clk;

    mc_shift_alu #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in),
        .x_load(x_load), .y_load(y_load), .ctrl(ctrl), .cin(cin),
        .z_en(z_en), .z_out(z_out), .flag_zero(flag_zero),
        .flag_sign(flag_sign), .flag_overflow(flag_overflow),
        .flag_carry(flag_carry)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements: returns {z_next, flags}
    function automatic void model(input int cw, input int ci, input int xv, input int yv,
                                  output int res, output int fl, output int shifted);
        int a, b, p, q, s, c, ov, r;
        bit arith;
        case ((cw >> 5) & 3)
            0: begin a = xv; b = yv; end
            1: begin a = xv; b = 0;  end
            2: begin a = yv; b = 0;  end
            default: begin a = yv; b = xv; end
        endcase
        arith = 1; p = a; q = b;
        case ((cw >> 2) & 7)
            0: begin p = a; q = b; end
            1: begin p = a; q = (~b) & 255; end
            2: begin p = b; q = (~a) & 255; end
            default: arith = 0;
        endcase
        s = p + q + ci;
        case ((cw >> 2) & 7)
            3: r = a | b;
            4: r = a & b;
            5: r = (~a) & b & 255;
            6: r = a ^ b;
            7: r = (~(a ^ b)) & 255;
            default: r = s & 255;
        endcase
        c  = arith ? ((s >> 8) & 1) : 0;
        ov = (arith && ((p >> 7) == (q >> 7)) && (((r >> 7) & 1) != (p >> 7))) ? 1 : 0;
        res = r;
        fl = ((r == 0) ? 8 : 0) | (((r >> 7) & 1) << 2) | (ov << 1) | c;
        case (cw & 3)
            1: shifted = (r >> 1) | (r & 128);
            2: shifted = (r << 1) & 255;
            default: shifted = r;
        endcase
    endfunction

    // Driver: load operands, run one control word, push the expectation
    task automatic run_op(input int xv, input int yv, input bit lx, input bit ly,
                          input int cw, input bit ci, input bit en, input string tag);
        int r, fl, sh;
        @(posedge clk); #1;
        x_in = W'(xv); y_in = W'(yv); x_load = lx; y_load = ly; z_en = 1'b0;
        @(posedge clk); #1;
        if (lx) xm = xv;
        if (ly) ym = yv;
        x_load = 1'b0; y_load = 1'b0;
        ctrl = 7'(cw); cin = ci; z_en = en;
        model(cw, ci, xm, ym, r, fl, sh);
        @(posedge clk); #1;
        if (en && ((cw & 3) != 3)) zm = sh;
        sb_q.push_back('{z: W'(zm), flags: 4'(fl), tag: tag});
        z_en = 1'b0;
    endtask

    // Monitor: compare Z and flags at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(z_out == e.z, {e.tag, " z"}, int'(z_out), int'(e.z));
            check({flag_zero, flag_sign, flag_overflow, flag_carry} == e.flags,
                  {e.tag, " flags"},
                  int'({flag_zero, flag_sign, flag_overflow, flag_carry}), int'(e.flags));
        end
    end

    // Watchdog
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(z_out == 0, "R10 reset z", int'(z_out), 0);
        check(flag_zero == 1'b1, "R10 reset x/y zero", int'(flag_zero), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R2 / R6 add across signed limit: 0x7F + 0x01 -> 0x80, ovf=1 carry=0
        run_op(8'h7F, 8'h01, 1, 1, 7'b00_000_00, 0, 1, "R2 R6 add ovf");
        // R2 add with cin and carry-out: 0xF0 + 0x20 + 1 = 0x111
        run_op(8'hF0, 8'h20, 1, 1, 7'b00_000_00, 1, 1, "R2 add carry");
        // R3 equal operands, cin=1 -> zero, no borrow (carry=1)
        run_op(8'h3C, 8'h3C, 1, 1, 7'b00_001_00, 1, 1, "R3 sub equal");
        // R3 cin=0 extra borrow
        run_op(8'h10, 8'h03, 1, 1, 7'b00_001_00, 0, 1, "R3 sub borrow");
        // R4 Y-X with X>Y: 3-5 = 0xFE, sign=1
        run_op(8'h05, 8'h03, 1, 1, 7'b00_010_00, 1, 1, "R4 rsub x>y");
        check(flag_sign == 1'b1, "R4 sign x>y", int'(flag_sign), 1);
        run_op(8'h03, 8'h05, 1, 1, 7'b00_010_00, 1, 1, "R4 rsub x<y");
        // R6 sub overflow: 0x80 - 0x01
        run_op(8'h80, 8'h01, 1, 1, 7'b00_001_00, 1, 1, "R6 sub ovf");
        // R5 bitwise codes
        run_op(8'hCA, 8'h5C, 1, 1, 7'b00_011_00, 1, 1, "R5 or");
        run_op(8'hCA, 8'h5C, 1, 1, 7'b00_100_00, 1, 1, "R5 and");
        run_op(8'hCA, 8'h5C, 1, 1, 7'b00_101_00, 1, 1, "R5 andn");
        run_op(8'hCA, 8'h5C, 1, 1, 7'b00_110_00, 1, 1, "R5 xor");
        run_op(8'hCA, 8'h5C, 1, 1, 7'b00_111_00, 1, 1, "R5 xnor");
        // R1 routes, asymmetric operands with non-commutative reverse subtract
        run_op(8'h21, 8'h07, 1, 1, 7'b01_010_00, 1, 1, "R1 route x0");
        run_op(8'h21, 8'h07, 1, 1, 7'b10_010_00, 1, 1, "R1 route y0");
        run_op(8'h21, 8'h07, 1, 1, 7'b11_010_00, 1, 1, "R1 route yx");
        // R8 / R1 route 10, XNOR with 0, doubled: ~Y << 1
        run_op(8'h00, 8'h35, 1, 1, 7'b10_111_10, 0, 1, "R8 not y double");
        check(z_out == 8'h94, "R8 not y double value", int'(z_out), 8'h94);
        // R8 halve a negative value keeps sign: 0x90 -> 0xC8
        run_op(8'h90, 8'h00, 1, 1, 7'b01_000_01, 0, 1, "R8 halve neg");
        // R7 zero flag independent of shift: 0x80 doubled -> Z=0 but flag_zero=0
        run_op(8'h80, 8'h00, 1, 1, 7'b01_000_10, 0, 1, "R7 pre-shift flags");
        // R9 hold code: Z keeps previous value
        run_op(8'h11, 8'h22, 1, 1, 7'b00_000_11, 0, 1, "R9 hold code");
        // R9 z_en low
        run_op(8'h44, 8'h01, 1, 1, 7'b00_000_00, 0, 0, "R9 z_en low");
        // R11 load only X; Y must keep 0x01
        run_op(8'h50, 8'hEE, 1, 0, 7'b00_000_00, 0, 1, "R11 x only");
        // R11 load only Y; X must keep 0x50
        run_op(8'hAA, 8'h02, 0, 1, 7'b00_001_00, 1, 1, "R11 y only");

        // R10 mid-run reset clears X, Y, Z
        @(posedge clk); #1;
        ctrl = 7'b00_000_00; cin = 1'b0; z_en = 1'b1; rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1; z_en = 1'b0;
        xm = 0; ym = 0; zm = 0;
        sb_q.push_back('{z: '0, flags: 4'b1000, tag: "R10 mid reset"});
        @(posedge clk);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule